// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the address for each beat of a four-beat burst. A load strobe captures a full external address; the bits above the lowest two are held as captured, and the lowest two bits become the starting beat offset. Each later clock edge with the step input high moves the burst one beat forward. With the step input low the address holds, which gives a wait cycle. After the fourth beat the sequence wraps back to the start offset.

Two beat orders are offered, chosen by a static order-select input. In linear order each beat adds one, modulo four, to the start offset. In interleaved order each beat is the start offset XORed with the number of beats taken so far. A flag marks the fourth beat of the block. The block sits between an address-strobe decoder, which raises the load strobe, and a memory array, which consumes the address.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is high, the next clock edge sets addr_o to zero, offset_o to 0 and last_o low.
- R2: A clock edge with load_i high captures load_addr_i: from the next cycle addr_o equals load_addr_i, and that beat is beat zero.
- R3: A clock edge with step_i high and load_i low moves the burst forward by exactly one beat.
- R4: A clock edge with both step_i and load_i low leaves addr_o and last_o unchanged (wait cycle).
- R5: With order_sel_i = 0 (linear), beat n has offset (start + n) modulo 4; for example start 01 gives 01, 10, 11, 00.
- R6: With order_sel_i = 1 (interleaved), beat n has offset start XOR n; for example start 01 gives 01, 00, 11, 10.
- R7: The bits of addr_o above bit 1 stay equal to the captured value until the next load, whatever the step input does.
- R8: last_o is high exactly on the fourth beat (beat number 3) and low on beats zero to two.
- R9: A step taken from the fourth beat returns to beat zero, whose offset is the start offset.
- R10: When load_i and step_i are both high on the same edge, the load wins and the new address is beat zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture load_addr_i and restart the burst |
| load_addr_i | input | ADDR_W | External address captured on load |
| step_i | input | 1 | Advance one beat; low gives a wait cycle |
| order_sel_i | input | 1 | Beat order: 0 linear, 1 interleaved (static) |
| addr_o | output | ADDR_W | Captured upper bits with the current beat offset in bits 1:0 |
| offset_o | output | 2 | Current beat offset |
| last_o | output | 1 | High on the fourth beat of the burst |

## Verification
Every effect of load, step and reset appears on the outputs one clock edge after the edge that samples it, since each goes through one register stage, while the order select acts on the offset within the same cycle through logic alone. The bench drives inputs on the falling edge, updates its behavioural model on the rising edge that the design also samples, and compares address, offset and last flag on the following falling edge, so each result is checked in the exact cycle it becomes due. The sequences cover both orders from every start offset, wraps, waits mid-burst and colliding load and step.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;

    typedef struct packed {
        beat_t start;
        beat_t count;
    } burst_pos_t;

    function automatic beat_t map_beat(order_e ord, beat_t start, beat_t n);
        beat_t r;
        if (ord == ORD_LINEAR) r = start + n;
        else                   r = start ^ n;
        return r;
    endfunction

    function automatic logic is_final(beat_t n);
        return n == beat_t'(BEATS - 1);
    endfunction

endpackage

// File: rtl/burst_pos_reg.sv
module burst_pos_reg
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  beat_t      start_i,
    input  logic       step_i,
    output burst_pos_t pos_o
);
    burst_pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (load_i) begin
            pos_q.start <= start_i;
            pos_q.count <= '0;
        end else if (step_i) begin
            pos_q.count <= pos_q.count + beat_t'(1);
        end
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  order_e     order_i,
    input  burst_pos_t pos_i,
    output beat_t      ofs_o,
    output logic       last_o
);
    always_comb begin
        ofs_o  = map_beat(order_i, pos_i.start, pos_i.count);
        last_o = is_final(pos_i.count);
    end
endmodule

// File: rtl/upper_addr_reg.sv
module upper_addr_reg #(
    parameter int UP_W = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [UP_W-1:0] d_i,
    output logic [UP_W-1:0] q_o
);
    logic [UP_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (load_i) q <= d_i;
    end

    assign q_o = q;
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              step_i,
    input  logic              order_sel_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        offset_o,
    output logic              last_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    burst_pos_t      pos;
    beat_t           ofs;
    logic            fin;
    logic [UP_W-1:0] upper;
    order_e          ord;

    assign ord = order_e'(order_sel_i);

    burst_pos_reg pos_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .start_i (load_addr_i[BEAT_W-1:0]),
        .step_i  (step_i),
        .pos_o   (pos)
    );

    burst_order_map map_i (
        .order_i (ord),
        .pos_i   (pos),
        .ofs_o   (ofs),
        .last_o  (fin)
    );

    upper_addr_reg #(.UP_W(UP_W)) up_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .d_i    (load_addr_i[ADDR_W-1:BEAT_W]),
        .q_o    (upper)
    );

    assign addr_o   = {upper, ofs};
    assign offset_o = ofs;
    assign last_o   = fin;
endmodule

// File: rtl/burst_seq_gen_chk.sv
module burst_seq_gen_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic [ADDR_W-1:0] load_addr_i,
    input logic              step_i,
    input logic              order_sel_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        offset_o,
    input logic              last_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (addr_o == '0 && !last_o)); // R1

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_o == $past(load_addr_i) && !last_o)); // R2

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (load_i && step_i) |=> (offset_o == $past(load_addr_i[1:0]))); // R10

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_i) |=> (($stable(addr_o) && $stable(last_o)) || !$stable(order_sel_i))); // R4

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(addr_o[ADDR_W-1:2])); // R7

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && !order_sel_i) |=>
        ((offset_o == $past(offset_o) + 2'd1) || order_sel_i)); // R5

    AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (last_o && step_i && !load_i) |=> !last_o); // R9
endmodule

bind burst_seq_gen burst_seq_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .load_addr_i (load_addr_i),
    .step_i      (step_i),
    .order_sel_i (order_sel_i),
    .addr_o      (addr_o),
    .offset_o    (offset_o),
    .last_o      (last_o)
);

// File: tb/burst_seq_gen_tb_top.sv
module burst_seq_gen_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic          step_i = 1'b0;
    logic          order_sel_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic [1:0]    offset_o;
    logic          last_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int m_start = 0;
    int m_beat = 0;
    int m_upper = 0;

    always #10 clk = ~clk;

    burst_seq_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .load_i(load_i), .load_addr_i(load_addr_i),
        .step_i(step_i), .order_sel_i(order_sel_i),
        .addr_o(addr_o), .offset_o(offset_o), .last_o(last_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_start = 0; m_beat = 0; m_upper = 0;
        end else if (load_i) begin
            m_start = int'(load_addr_i) % 4;
            m_upper = int'(load_addr_i) / 4;
            m_beat  = 0;
        end else if (step_i) begin
            m_beat = (m_beat + 1) % 4;
        end
    end

    function automatic int exp_ofs();
        if (order_sel_i) return m_start ^ m_beat;
        return (m_start + m_beat) % 4;
    endfunction

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(tag, int'(offset_o), exp_ofs());
        check({tag, "/R7"}, int'(addr_o[AW-1:2]), m_upper);
        check({tag, "/R8"}, int'(last_o), (m_beat == 3) ? 1 : 0);
    endtask

    // one cycle: check current outputs, then drive inputs for the next edge
    task automatic cyc(bit ld, int ad, bit st);
        @(negedge clk);
        compare_all();
        load_i = ld;
        load_addr_i = AW'(ad);
        step_i = st;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        cyc(0, 0, 0);
        @(negedge clk); rst = 1'b0;

        // R2 R5 R9: linear from 01, six steps then wait
        order_sel_i = 1'b0;
        tag = "R2";
        cyc(1, 16'h1235, 0);
        tag = "R5";
        for (int i = 0; i < 6; i++) cyc(0, 0, 1);
        tag = "R9";
        cyc(0, 0, 1);
        tag = "R4";
        for (int i = 0; i < 3; i++) cyc(0, 16'hFFFF, 0);
        cyc(0, 0, 1);
        cyc(0, 0, 0);

        // R6: interleaved from 01
        order_sel_i = 1'b1;
        tag = "R2";
        cyc(1, 16'hABC1, 0);
        tag = "R6";
        for (int i = 0; i < 5; i++) cyc(0, 16'h5555, 1);
        tag = "R4";
        cyc(0, 0, 0);
        cyc(0, 0, 0);

        // R10: load and step together, both orders
        tag = "R10";
        cyc(1, 16'h0F0E, 1);
        cyc(1, 16'h7003, 1);
        order_sel_i = 1'b0;
        cyc(0, 0, 1);
        cyc(1, 16'h2222, 1);
        cyc(0, 0, 1);

        // R3 R5 R6 R8: every start offset in both orders, with waits
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                order_sel_i = o[0];
                tag = "R2";
                cyc(1, (s * 1237 + o * 40000) * 4 % 65536 + s, 0);
                tag = o ? "R6" : "R5";
                for (int k = 0; k < 9; k++) cyc(0, 16'h3C3C, (k % 3) != 1);
                tag = "R3";
                cyc(0, 0, 1);
            end
        end

        // R1: reset mid burst
        tag = "R1";
        @(negedge clk); compare_all(); rst = 1'b1; step_i = 1'b1;
        cyc(0, 0, 1);
        @(negedge clk); compare_all(); rst = 1'b0; step_i = 1'b0;
        cyc(0, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule